// File: doc/BRIEF.md
# Audio Ring-Buffer DMA Channel Pair

This block moves 32-bit audio words between a memory ring buffer and the FIFO of a serial audio port. It holds one playback (transmit) channel and one record (receive) channel. Each channel runs through the memory region given by a programmed start address and byte count. It takes one word for each FIFO request it accepts. It marks the point where half of the region has been crossed with one event pulse, and the end of the region with a second pulse. A driver that keeps two periods in flight treats each of these events as a finished period.

Software programs a start address and a byte count for each channel, then starts the channel through a control word that the two channels share. In that word, enable and force-stop are write-one strobes. With auto-reload set, a channel returns to its start address at the end of the region and keeps running, which gives a ring. Without auto-reload, it stops and drops its enable bit. The running byte count of each channel can be read back at any time. A two-bit packing mode per channel is stored and handed to the serial port.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset every register reads 0, both channels are idle, no word is acknowledged and all four event lines are low.
- R2: Word offsets are: transmit start address 0x00 and receive start address 0x04, both 32 bits wide. Transmit byte count is at 0x08 and receive byte count at 0x0C, each holding bits 25:0, with the upper bits reading 0. The control word is at 0x10. The transmit running count is at 0x14 and the receive running count at 0x18. Any other offset, and any address whose bits 1:0 are not 00, reads 0 and ignores writes.
- R3: The control word places the transmit fields at bits 0 (enable), 1 (force stop), 2 (auto-reload) and 9:8 (packing mode: 0 none, 1 four-byte, 2 two-word). The receive fields sit at the same positions plus 16. Force-stop bits read 0 and enable bits read 1 while the channel is active. The packing modes drive tx_align and rx_align.
- R4: Writing 1 to an idle channel's enable bit starts it on the next cycle, with its address at the start address and its running count at 0. This happens only when the byte count is a multiple of 4 and at least 8. Otherwise the channel stays idle.
- R5: In any cycle where a channel is active, its request is high and no force stop is being written for it, the channel acknowledges in that same cycle at its current address. Data passes straight through. The address and the running count then each advance by 4.
- R6: The cycle after an accepted word lifts the running count from below half the byte count to at least half, a one-cycle half event appears: irq bit 0 for transmit, bit 2 for receive.
- R7: The cycle after an accepted word brings the running count to the byte count, a one-cycle full event appears: irq bit 1 for transmit, bit 3 for receive.
- R8: With auto-reload set, that final word returns the address to the start address and the running count to 0, and the channel stays active.
- R9: Without auto-reload, that final word clears the channel's enable bit. The running count then holds the byte count.
- R10: Writing 1 to a force-stop bit makes the channel idle on the next cycle and keeps its running count. A word requested in that same cycle is not acknowledged and raises no event. Force stop wins over an enable written in the same word.
- R11: While a channel is active, writes to its start address and byte count are ignored, and writing its enable bit again neither restarts it nor changes its count.
- R12: The two channels run independently and may both acknowledge and raise events in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| tx_req | input | 1 | Playback FIFO asks for a word |
| tx_ack | output | 1 | Playback word accepted this cycle |
| tx_addr | output | 32 | Memory read address of the playback word |
| tx_mem_data | input | 32 | Word read from memory |
| tx_fifo_data | output | 32 | Word pushed to the playback FIFO |
| tx_align | output | 2 | Playback packing mode |
| rx_req | input | 1 | Record FIFO offers a word |
| rx_ack | output | 1 | Record word accepted this cycle |
| rx_addr | output | 32 | Memory write address of the record word |
| rx_fifo_data | input | 32 | Word popped from the record FIFO |
| rx_mem_data | output | 32 | Word written to memory |
| rx_align | output | 2 | Record packing mode |
| irq | output | 4 | Event pulses: transmit half, transmit full, receive half, receive full (bit 0 upward) |

## Verification
The collision that matters is a force stop written in the same cycle as a requested word, above all the word that would end the region. The bench starts an 8-byte transfer, lets one word through, then writes the stop bit while the request is still high. It expects no acknowledge, no full event in the next cycle, and a running count frozen at 4. The random phase also throws stop bits at the channels while requests are held high. Every cycle, it compares acknowledge, address and event lines against a model kept from the requirements.

// File: rtl/ardma_pkg.sv
package ardma_pkg;

  // Two channels: index 0 plays back, index 1 records.
  localparam int unsigned NCH      = 2;
  // Receive fields sit this many bits above the transmit fields.
  localparam int unsigned CH_OFS   = 16;
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_STOP = 1;
  localparam int unsigned BIT_RLD  = 2;
  localparam int unsigned BIT_ALN  = 8;
  localparam int unsigned RADDR_W  = 5;

  // Word index (byte address bits 4:2) of each register.
  localparam logic [2:0] IDX_BASE0 = 3'd0;
  localparam logic [2:0] IDX_LEN0  = 3'd2;
  localparam logic [2:0] IDX_CTRL  = 3'd4;
  localparam logic [2:0] IDX_CNT0  = 3'd5;

  typedef struct packed {
    logic       reload;
    logic [1:0] align;
  } chan_cfg_t;

endpackage

// File: rtl/ardma_chan.sv
module ardma_chan #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              reload_i,
  input  logic              req_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              active_o,
  output logic              half_o,
  output logic              full_o
);

  localparam int unsigned       STEP    = DATA_W / 8;
  localparam int unsigned       STEP_LG = $clog2(STEP);
  localparam logic [CNT_W-1:0]  STEP_C  = CNT_W'(STEP);
  localparam logic [CNT_W-1:0]  MIN_LEN = CNT_W'(2 * STEP);
  localparam logic [DATA_W-1:0] STEP_A  = DATA_W'(STEP);

  logic              act_q,  act_d;
  logic [DATA_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic              half_q, half_d;
  logic              full_q, full_d;
  logic              len_ok;
  logic [CNT_W-1:0]  half_len;
  logic [CNT_W-1:0]  cnt_inc;

  assign len_ok   = (len_i[STEP_LG-1:0] == '0) && (len_i >= MIN_LEN);
  assign half_len = len_i >> 1;
  assign cnt_inc  = cnt_q + STEP_C;
  assign ack_o    = act_q & req_i & ~stop_i;

  // Next-state: stop first, then start of an idle channel, then a word.
  always_comb begin
    act_d  = act_q;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    half_d = 1'b0;
    full_d = 1'b0;
    if (stop_i) begin
      act_d = 1'b0;
    end else if (!act_q) begin
      if (start_i && len_ok) begin
        act_d  = 1'b1;
        addr_d = base_i;
        cnt_d  = '0;
      end
    end else if (req_i) begin
      addr_d = addr_q + STEP_A;
      cnt_d  = cnt_inc;
      half_d = (cnt_q < half_len) && (cnt_inc >= half_len);
      if (cnt_inc == len_i) begin
        full_d = 1'b1;
        if (reload_i) begin
          addr_d = base_i;
          cnt_d  = '0;
        end else begin
          act_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      half_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      half_q <= half_d;
      full_q <= full_d;
    end
  end

  assign addr_o   = addr_q;
  assign cnt_o    = cnt_q;
  assign active_o = act_q;
  assign half_o   = half_q;
  assign full_o   = full_q;

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !act_q);

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> (cnt_q == $past(cnt_q) + STEP_C) || (cnt_q == '0));

  // R6
  half_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_q |=> !half_q);

  // R7
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(half_q && full_q));

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < len_i));

  // R4
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i && !act_q && len_ok) |=> (act_q && cnt_q == '0));

endmodule

// File: rtl/ardma_regs.sv
module ardma_regs
  import ardma_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 26
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_i,
  input  logic                         hit_i,
  input  logic [2:0]                   idx_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [NCH-1:0]               act_i,
  input  logic [NCH-1:0][CNT_W-1:0]    cnt_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [NCH-1:0][DATA_W-1:0]   base_o,
  output logic [NCH-1:0][CNT_W-1:0]    len_o,
  output chan_cfg_t [NCH-1:0]          cfg_o,
  output logic [NCH-1:0]               start_o,
  output logic [NCH-1:0]               stop_o
);

  logic              ctrl_we;
  logic [DATA_W-1:0] ctrl_word;

  assign ctrl_we = wr_i & hit_i & (idx_i == IDX_CTRL);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned OFS = c * CH_OFS;

    logic              base_we, len_we;
    logic [DATA_W-1:0] base_q;
    logic [CNT_W-1:0]  len_q;
    chan_cfg_t         cfg_q, cfg_d;

    assign base_we = wr_i & hit_i & (idx_i == IDX_BASE0 + 3'(c)) & ~act_i[c];
    assign len_we  = wr_i & hit_i & (idx_i == IDX_LEN0 + 3'(c)) & ~act_i[c];

    always_comb begin
      cfg_d.reload = wdata_i[OFS + BIT_RLD];
      cfg_d.align  = wdata_i[OFS + BIT_ALN +: 2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        len_q  <= '0;
        cfg_q  <= '0;
      end else begin
        if (base_we) base_q <= wdata_i;
        if (len_we)  len_q  <= wdata_i[CNT_W-1:0];
        if (ctrl_we) cfg_q  <= cfg_d;
      end
    end

    assign base_o[c]  = base_q;
    assign len_o[c]   = len_q;
    assign cfg_o[c]   = cfg_q;
    assign start_o[c] = ctrl_we & wdata_i[OFS + BIT_EN];
    assign stop_o[c]  = ctrl_we & wdata_i[OFS + BIT_STOP];

    // R11
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i[c] && wr_i) |=> $stable(base_q));

    // R11
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i[c] && wr_i) |=> $stable(len_q));
  end

  always_comb begin
    ctrl_word = '0;
    for (int c = 0; c < NCH; c++) begin
      ctrl_word[c*CH_OFS + BIT_EN]        = act_i[c];
      ctrl_word[c*CH_OFS + BIT_RLD]       = cfg_o[c].reload;
      ctrl_word[c*CH_OFS + BIT_ALN +: 2]  = cfg_o[c].align;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      case (idx_i)
        IDX_BASE0:        rdata_o = base_o[0];
        IDX_BASE0 + 3'd1: rdata_o = base_o[1];
        IDX_LEN0:         rdata_o = DATA_W'(len_o[0]);
        IDX_LEN0 + 3'd1:  rdata_o = DATA_W'(len_o[1]);
        IDX_CTRL:         rdata_o = ctrl_word;
        IDX_CNT0:         rdata_o = DATA_W'(cnt_i[0]);
        IDX_CNT0 + 3'd1:  rdata_o = DATA_W'(cnt_i[1]);
        default:          rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/audio_ring_dma.sv
module audio_ring_dma
  import ardma_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               tx_req,
  output logic               tx_ack,
  output logic [DATA_W-1:0]  tx_addr,
  input  logic [DATA_W-1:0]  tx_mem_data,
  output logic [DATA_W-1:0]  tx_fifo_data,
  output logic [1:0]         tx_align,
  input  logic               rx_req,
  output logic               rx_ack,
  output logic [DATA_W-1:0]  rx_addr,
  input  logic [DATA_W-1:0]  rx_fifo_data,
  output logic [DATA_W-1:0]  rx_mem_data,
  output logic [1:0]         rx_align,
  output logic [2*NCH-1:0]   irq
);

  logic [1:0]                rsync_q;
  logic                      rst_int_n;
  logic                      hit;
  logic [NCH-1:0]            req, ack, act, start, stop, half, full;
  logic [NCH-1:0][DATA_W-1:0] base, addr;
  logic [NCH-1:0][CNT_W-1:0] len, cnt;
  chan_cfg_t [NCH-1:0]       cfg;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign hit = (reg_addr[1:0] == 2'b00);

  ardma_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_i    (reg_wr),
    .hit_i   (hit),
    .idx_i   (reg_addr[RADDR_W-1:2]),
    .wdata_i (reg_wdata),
    .act_i   (act),
    .cnt_i   (cnt),
    .rdata_o (reg_rdata),
    .base_o  (base),
    .len_o   (len),
    .cfg_o   (cfg),
    .start_o (start),
    .stop_o  (stop)
  );

  assign req = {rx_req, tx_req};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    ardma_chan #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .start_i  (start[c]),
      .stop_i   (stop[c]),
      .base_i   (base[c]),
      .len_i    (len[c]),
      .reload_i (cfg[c].reload),
      .req_i    (req[c]),
      .ack_o    (ack[c]),
      .addr_o   (addr[c]),
      .cnt_o    (cnt[c]),
      .active_o (act[c]),
      .half_o   (half[c]),
      .full_o   (full[c])
    );
    assign irq[2*c]   = half[c];
    assign irq[2*c+1] = full[c];
  end

  assign tx_ack       = ack[0];
  assign tx_addr      = addr[0];
  assign tx_fifo_data = tx_mem_data;
  assign tx_align     = cfg[0].align;
  assign rx_ack       = ack[1];
  assign rx_addr      = addr[1];
  assign rx_mem_data  = rx_fifo_data;
  assign rx_align     = cfg[1].align;

  // R1
  idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (irq == '0));

  // R12
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq[1] || irq[0]) |-> $past(tx_ack));

endmodule

// File: tb/audio_ring_dma_tb.sv
module audio_ring_dma_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        tx_req, tx_ack, rx_req, rx_ack;
  logic [31:0] tx_addr, tx_mem_data, tx_fifo_data;
  logic [31:0] rx_addr, rx_fifo_data, rx_mem_data;
  logic [1:0]  tx_align, rx_align;
  logic [3:0]  irq;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // Requirement model
  logic [31:0] m_base[2];
  logic [25:0] m_len[2];
  logic        m_act[2];
  logic [31:0] m_addr[2];
  logic [25:0] m_cnt[2];
  logic        m_rel[2];
  logic [1:0]  m_al[2];
  logic [3:0]  m_irq;

  // Extra directed read check
  bit          x_en = 0;
  logic [31:0] x_rd;
  logic [3:0]  x_irq;
  string       x_tag;

  always #5 clk = ~clk;

  audio_ring_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_req(tx_req), .tx_ack(tx_ack), .tx_addr(tx_addr),
    .tx_mem_data(tx_mem_data), .tx_fifo_data(tx_fifo_data), .tx_align(tx_align),
    .rx_req(rx_req), .rx_ack(rx_ack), .rx_addr(rx_addr),
    .rx_fifo_data(rx_fifo_data), .rx_mem_data(rx_mem_data), .rx_align(rx_align),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [4:0] a);
    logic [31:0] r = '0;
    if (a[1:0] == 2'b00) begin
      case (a[4:2])
        3'd0: r = m_base[0];
        3'd1: r = m_base[1];
        3'd2: r = {6'd0, m_len[0]};
        3'd3: r = {6'd0, m_len[1]};
        3'd4: for (int c = 0; c < 2; c++) begin
                r[c*16]      = m_act[c];
                r[c*16+2]    = m_rel[c];
                r[c*16+8 +: 2] = m_al[c];
              end
        3'd5: r = {6'd0, m_cnt[0]};
        3'd6: r = {6'd0, m_cnt[1]};
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic bit len_valid(input logic [25:0] l);
    return (l[1:0] == 2'b00) && (l >= 26'd8);
  endfunction

  task automatic model_step(input logic wr, input logic [4:0] a, input logic [31:0] d,
                            input logic txr, input logic rxr);
    logic [3:0] ni = '0;
    bit old_act[2];
    bit ctrlw = wr && (a == 5'h10);
    for (int c = 0; c < 2; c++) begin
      logic rq = (c == 0) ? txr : rxr;
      logic [25:0] ci = m_cnt[c] + 26'd4;
      logic [25:0] hl = m_len[c] >> 1;
      old_act[c] = m_act[c];
      if (ctrlw && d[c*16+1]) m_act[c] = 1'b0;
      else if (!m_act[c]) begin
        if (ctrlw && d[c*16] && len_valid(m_len[c])) begin
          m_act[c] = 1'b1; m_addr[c] = m_base[c]; m_cnt[c] = '0;
        end
      end else if (rq) begin
        if (m_cnt[c] < hl && ci >= hl) ni[2*c] = 1'b1;
        m_addr[c] = m_addr[c] + 32'd4;
        m_cnt[c] = ci;
        if (ci == m_len[c]) begin
          ni[2*c+1] = 1'b1;
          if (m_rel[c]) begin m_addr[c] = m_base[c]; m_cnt[c] = '0; end
          else m_act[c] = 1'b0;
        end
      end
    end
    if (wr && a[1:0] == 2'b00) begin
      case (a[4:2])
        3'd0: if (!old_act[0]) m_base[0] = d;
        3'd1: if (!old_act[1]) m_base[1] = d;
        3'd2: if (!old_act[0]) m_len[0] = d[25:0];
        3'd3: if (!old_act[1]) m_len[1] = d[25:0];
        3'd4: for (int c = 0; c < 2; c++) begin
                m_rel[c] = d[c*16+2];
                m_al[c]  = d[c*16+8 +: 2];
              end
        default: ;
      endcase
    end
    m_irq = ni;
  endtask

  task automatic cycle(input logic wr, input logic [4:0] a, input logic [31:0] d,
                       input logic txr, input logic rxr);
    bit ctrlw = wr && (a == 5'h10);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; tx_req = txr; rx_req = rxr;
    tx_mem_data = $urandom; rx_fifo_data = $urandom;
    #1;
    chk("R5 tx_ack", {31'd0, tx_ack}, {31'd0, m_act[0] & txr & ~(ctrlw & d[1])});
    chk("R12 rx_ack", {31'd0, rx_ack}, {31'd0, m_act[1] & rxr & ~(ctrlw & d[17])});
    if (m_act[0]) chk("R5 tx_addr", tx_addr, m_addr[0]);
    if (m_act[1]) chk("R12 rx_addr", rx_addr, m_addr[1]);
    chk("R5 passthrough", tx_fifo_data ^ rx_mem_data, tx_mem_data ^ rx_fifo_data);
    chk("R6 half events", {30'd0, irq[2], irq[0]}, {30'd0, m_irq[2], m_irq[0]});
    chk("R7 full events", {30'd0, irq[3], irq[1]}, {30'd0, m_irq[3], m_irq[1]});
    chk("R3 align ports", {28'd0, rx_align, tx_align}, {28'd0, m_al[1], m_al[0]});
    if (!wr) chk((a == 5'h10) ? "R3 control read" : "R2 register read", reg_rdata, m_read(a));
    if (x_en) begin
      chk(x_tag, reg_rdata, x_rd);
      chk(x_tag, {28'd0, irq}, {28'd0, x_irq});
      x_en = 0;
    end
    @(posedge clk);
    model_step(wr, a, d, txr, rxr);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cycle(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic rdi(input logic [4:0] a, input logic [31:0] e, input logic [3:0] ei,
                     input string tag);
    x_en = 1; x_rd = e; x_irq = ei; x_tag = tag;
    cycle(1'b0, a, 32'd0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0A1D);
    for (int c = 0; c < 2; c++) begin
      m_base[c] = '0; m_len[c] = '0; m_act[c] = 0; m_addr[c] = '0;
      m_cnt[c] = '0; m_rel[c] = 0; m_al[c] = '0;
    end
    m_irq = '0;
    rst_n = 1'b0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    tx_req = 0; rx_req = 0; tx_mem_data = '0; rx_fifo_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) rdi(5'(a * 4), 32'd0, 4'd0, "R1 reset read");
    cycle(1'b0, 5'h00, 32'd0, 1'b1, 1'b1);

    // R2 programming and readback
    wr(5'h00, 32'h0000_1000);
    wr(5'h04, 32'h0000_2000);
    wr(5'h08, 32'd16);
    wr(5'h0C, 32'd8);
    rdi(5'h08, 32'd16, 4'd0, "R2 tx count");
    rdi(5'h04, 32'h2000, 4'd0, "R2 rx base");
    wr(5'h1C, 32'hFFFF_FFFF);
    rdi(5'h1C, 32'd0, 4'd0, "R2 unmapped");

    // R3/R4 start both channels: tx reload align 2, rx no reload align 1
    wr(5'h10, 32'h0101_0205);
    rdi(5'h10, 32'h0101_0205, 4'd0, "R3 control fields");

    // R12 both running together; R8 tx wraps; R9 rx ends
    for (int i = 0; i < 4; i++) cycle(1'b0, 5'h14, 32'd0, 1'b1, 1'b1);
    rdi(5'h18, 32'd8, 4'b0010, "R9 rx count holds length");
    rdi(5'h10, 32'h0100_0205, 4'd0, "R9 rx enable cleared");
    rdi(5'h14, 32'd0, 4'd0, "R8 tx count reloaded");

    // R11 writes while active ignored
    wr(5'h08, 32'h40);
    rdi(5'h08, 32'd16, 4'd0, "R11 count write ignored");
    wr(5'h00, 32'h5000);
    rdi(5'h00, 32'h1000, 4'd0, "R11 base write ignored");
    cycle(1'b0, 5'h14, 32'd0, 1'b1, 1'b0);
    wr(5'h10, 32'h0000_0205);
    rdi(5'h14, 32'd4, 4'd0, "R11 no restart");

    // R10 stop while requesting
    cycle(1'b1, 5'h10, 32'h0000_0003, 1'b1, 1'b0);
    rdi(5'h10, 32'd0, 4'd0, "R10 stopped, stop reads 0");
    rdi(5'h14, 32'd4, 4'd0, "R10 count held");

    // R4 rejected lengths
    wr(5'h08, 32'd6);  wr(5'h10, 32'd1); rdi(5'h10, 32'd0, 4'd0, "R4 unaligned length");
    wr(5'h08, 32'd4);  wr(5'h10, 32'd1); rdi(5'h10, 32'd0, 4'd0, "R4 short length");
    wr(5'h08, 32'd0);  wr(5'h10, 32'd1); rdi(5'h10, 32'd0, 4'd0, "R4 zero length");

    // R6/R7 half at 6 of 12
    wr(5'h08, 32'd12); wr(5'h10, 32'd1);
    cycle(1'b0, 5'h14, 32'd0, 1'b1, 1'b0);
    cycle(1'b0, 5'h14, 32'd0, 1'b1, 1'b0);
    rdi(5'h14, 32'd8, 4'b0001, "R6 half event");
    cycle(1'b0, 5'h14, 32'd0, 1'b1, 1'b0);
    rdi(5'h10, 32'd0, 4'b0010, "R7 full event, R9 idle");

    // R10 collision: stop with the final word of an 8-byte region
    wr(5'h08, 32'd8); wr(5'h10, 32'd1);
    cycle(1'b0, 5'h14, 32'd0, 1'b1, 1'b0);
    cycle(1'b1, 5'h10, 32'h0000_0003, 1'b1, 1'b0);
    rdi(5'h14, 32'd4, 4'd0, "R10 stop beats final word");

    // Random phase
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom % 100;
      logic w = 1'b0;
      logic [4:0] a = 5'($urandom % 8) << 2;
      logic [31:0] d = '0;
      if (r < 4) begin
        w = 1; a = 5'h10;
        d = $urandom & 32'h0307_0307;
        if ($urandom % 4 != 0) d = d & ~32'h0002_0002;
      end else if (r < 8) begin
        w = 1; a = ($urandom % 2) ? 5'h08 : 5'h0C;
        d = ($urandom % 8 == 0) ? 32'($urandom % 64) : 32'(8 + 4 * ($urandom % 14));
      end else if (r < 10) begin
        w = 1; a = ($urandom % 2) ? 5'h00 : 5'h04;
        d = $urandom & 32'hFFFF_FFFC;
      end
      cycle(w, a, d, ($urandom % 4) != 0, ($urandom % 3) != 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule